// File: doc/BRIEF.md
# Shared-Memory Window Configuration Decoder

This block turns the configuration values held in a network card's serial EEPROM into the settings needed to open the card's shared-RAM window on the host bus. It takes the memory-configuration byte and the encoded interrupt field. From the byte it derives the base address and size of the RAM window and the four bytes that set up the card's address decoding: decode enable, memory control, page control and extended decode. It also translates the interrupt code into a host IRQ number.

A single-cycle `start` pulse captures the inputs. The result is built in a short pipeline and shown with a one-cycle `done` strobe. Every result output then keeps its value until the next result is written. If the caller gives an expected base or size, the block compares it with the decoded value and raises a mismatch flag. The decoded value is never replaced by the caller's value. Configurations the card cannot use are flagged as bad.

Top module: `shmwin_cfg_decoder`

## Requirements
- R1: `done` is high for exactly one cycle per accepted `start`. It rises in the cycle after the third rising edge, counting the edge that samples `start` as the first. A `start` on consecutive cycles gives `done` on consecutive cycles, in the same order.
- R2: `win_base` is 0xC0000 + i * 0x4000, where i (0 to 7) is the position of the lowest set bit of `mem_cfg`.
- R3: After the zero bits below bit i are removed, the value left in `mem_cfg` selects the window size. A value of 0x01, 0x03, 0x07 or 0x0F gives a `win_size` of 16384, 32768, 49152 or 65536 bytes.
- R4: `bad_cfg` is set when `mem_cfg` is zero or when the value left is any other value. In that case `win_base`, `win_size`, `page`, `dec_val`, `mctl_val`, `pgctl_val` and `xdec_val` are all zero and `mismatch` is 0.
- R5: `page` is bits 17..14 of `win_base`. `mctl_val` is 0x10 OR (`page` & 3) << 2.
- R6: The decode mask is ((1 << (size / 16 KiB)) - 1) << `page`. `dec_val` is the low byte of the mask and `pgctl_val` is the bitwise complement of that byte.
- R7: `xdec_val` is the low byte of ((~mask >> 4) & 0xF0) | (mask >> 8), computed on a 16-bit mask.
- R8: The 3-bit `irq_code` maps to an IRQ number as follows: 1→9, 2→3, 3→4, 4→5, 5→10, 6→11. For codes 0 and 7, `irq_none` is 1 and `irq_num` is 0. Otherwise `irq_none` is 0. The IRQ is decoded even when `bad_cfg` is set.
- R9: `mismatch` is set for a good configuration in either case: `want_base_vld` is 1 and `want_base` differs from the decoded base, or `want_size_vld` is 1 and `want_size` differs from the decoded size. `win_base` and `win_size` always show the decoded values.
- R10: Input changes without a `start` have no effect on the outputs. All result outputs hold their values between `done` pulses.
- R11: While `rst_n` is low, and after it is released, all outputs are zero until the first `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Capture inputs and begin a decode |
| mem_cfg | input | 8 | Memory-configuration byte from EEPROM |
| irq_code | input | 3 | Encoded interrupt field from the configuration word |
| want_base_vld | input | 1 | Compare the decoded base with `want_base` |
| want_base | input | 20 | Expected window base address |
| want_size_vld | input | 1 | Compare the decoded size with `want_size` |
| want_size | input | 17 | Expected window size in bytes |
| done | output | 1 | One-cycle result strobe |
| bad_cfg | output | 1 | Memory configuration not supported |
| mismatch | output | 1 | Expected base or size differs from the decoded value |
| win_base | output | 20 | Window base address |
| win_size | output | 17 | Window size in bytes |
| page | output | 4 | 16 KiB page number of the base |
| dec_val | output | 8 | Decode-enable register value |
| mctl_val | output | 8 | Memory-control register value |
| pgctl_val | output | 8 | Page-control register value |
| xdec_val | output | 8 | Extended-decode register value |
| irq_num | output | 4 | Host IRQ number |
| irq_none | output | 1 | Interrupt code maps to no IRQ |

## Verification
Every result is ready three register stages after `start` is sampled: capture, scan and output. The bench raises `start` on a falling edge, lowers it on the next falling edge, and checks that `done` is still low at the next two falling edges. It then reads `done` and every result on the third falling edge, where they must all be valid. On the falling edge after that it checks that `done` has dropped and that the results have not changed. For back-to-back starts it expects results on two consecutive falling edges, in order. For the hold check it changes the inputs without a start and reads the outputs again several cycles later.

// File: rtl/shmwin_pkg.sv
`timescale 1ns/1ps
package shmwin_pkg;
    localparam int MCFG_W = 8;
    localparam int IDX_W  = $clog2(MCFG_W);
    localparam int BLK_W  = 3;
    localparam int ADDR_W = 20;
    localparam int SIZE_W = 17;
    localparam int IRQ_W  = 3;
    localparam int IRQN_W = 4;

    typedef struct packed {
        logic              vld;
        logic [MCFG_W-1:0] mcfg;
        logic [IRQ_W-1:0]  irq;
        logic              wb_v;
        logic [ADDR_W-1:0] wb;
        logic              ws_v;
        logic [SIZE_W-1:0] ws;
    } cap_t;

    typedef struct packed {
        logic              vld;
        logic              ok;
        logic [IDX_W-1:0]  idx;
        logic [BLK_W-1:0]  blocks;
        logic [IRQ_W-1:0]  irq;
        logic              wb_v;
        logic [ADDR_W-1:0] wb;
        logic              ws_v;
        logic [SIZE_W-1:0] ws;
    } mid_t;

    typedef struct packed {
        logic              done;
        logic              bad;
        logic              mism;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [3:0]        page;
        logic [7:0]        dec;
        logic [7:0]        mctl;
        logic [7:0]        pgctl;
        logic [7:0]        xdec;
        logic [IRQN_W-1:0] irq_num;
        logic              irq_none;
    } res_t;

    typedef struct packed {
        cap_t c;
        mid_t m;
        res_t o;
    } state_t;

    function automatic logic [IRQN_W-1:0] irq_lookup(input logic [IRQ_W-1:0] code);
        case (code)
            3'd1:    irq_lookup = 4'd9;
            3'd2:    irq_lookup = 4'd3;
            3'd3:    irq_lookup = 4'd4;
            3'd4:    irq_lookup = 4'd5;
            3'd5:    irq_lookup = 4'd10;
            3'd6:    irq_lookup = 4'd11;
            default: irq_lookup = 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/shmwin_scan.sv
`timescale 1ns/1ps
module shmwin_scan
    import shmwin_pkg::*;
#(
    parameter int W = MCFG_W
) (
    input  logic [W-1:0]           cfg,
    output logic [$clog2(W)-1:0]   idx,
    output logic [BLK_W-1:0]       blocks,
    output logic                   ok
);
    localparam int IW = $clog2(W);

    logic [W-1:0] first_oh;
    logic [W-1:0] rest;
    logic [W-1:0] rest_inc;

    // one-hot marker of the lowest set bit
    generate
        for (genvar b = 0; b < W; b++) begin : g_first
            if (b == 0) begin : g_lsb
                assign first_oh[b] = cfg[b];
            end else begin : g_up
                assign first_oh[b] = cfg[b] & ~(|cfg[b-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int b = 0; b < W; b++) begin
            if (first_oh[b]) idx = idx | IW'(b);
        end
    end

    assign rest     = cfg >> idx;
    assign rest_inc = rest + W'(1);
    assign blocks   = BLK_W'($countones(rest));
    // contiguous run of ones, at most four 16 KiB blocks
    assign ok = (|cfg) && ((rest & rest_inc) == '0) && (rest <= W'(15));
endmodule

// File: rtl/shmwin_mask.sv
`timescale 1ns/1ps
module shmwin_mask
    import shmwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ORIGIN  = 20'hC0000,
    parameter int                PG_SH   = 14,
    parameter logic [7:0]        CS16_EN = 8'h10
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [BLK_W-1:0]  blocks,
    output logic [ADDR_W-1:0] base,
    output logic [SIZE_W-1:0] size,
    output logic [3:0]        page,
    output logic [7:0]        dec,
    output logic [7:0]        mctl,
    output logic [7:0]        pgctl,
    output logic [7:0]        xdec
);
    logic [15:0] run;
    logic [15:0] mask;
    logic [15:0] mask_n;

    assign base   = ORIGIN + (ADDR_W'(idx) << PG_SH);
    assign size   = SIZE_W'(blocks) << PG_SH;
    assign page   = base[PG_SH+3:PG_SH];
    assign run    = (16'd1 << blocks) - 16'd1;
    assign mask   = run << page;
    assign mask_n = ~mask;
    assign dec    = mask[7:0];
    assign pgctl  = ~mask[7:0];
    assign mctl   = CS16_EN | {4'd0, page[1:0], 2'd0};
    assign xdec   = 8'((mask_n >> 4) & 16'h00F0) | 8'(mask >> 8);
endmodule

// File: rtl/shmwin_irq.sv
`timescale 1ns/1ps
module shmwin_irq
    import shmwin_pkg::*;
(
    input  logic [IRQ_W-1:0]  code,
    output logic [IRQN_W-1:0] num,
    output logic              none
);
    assign num  = irq_lookup(code);
    assign none = (num == '0);
endmodule

// File: rtl/shmwin_cfg_decoder.sv
`timescale 1ns/1ps
module shmwin_cfg_decoder
    import shmwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ORIGIN  = 20'hC0000,
    parameter int                PG_SH   = 14,
    parameter logic [7:0]        CS16_EN = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [MCFG_W-1:0]     mem_cfg,
    input  logic [IRQ_W-1:0]      irq_code,
    input  logic                  want_base_vld,
    input  logic [ADDR_W-1:0]     want_base,
    input  logic                  want_size_vld,
    input  logic [SIZE_W-1:0]     want_size,
    output logic                  done,
    output logic                  bad_cfg,
    output logic                  mismatch,
    output logic [ADDR_W-1:0]     win_base,
    output logic [SIZE_W-1:0]     win_size,
    output logic [3:0]            page,
    output logic [7:0]            dec_val,
    output logic [7:0]            mctl_val,
    output logic [7:0]            pgctl_val,
    output logic [7:0]            xdec_val,
    output logic [IRQN_W-1:0]     irq_num,
    output logic                  irq_none
);
    state_t st_q, st_d;

    logic [IDX_W-1:0]  sc_idx;
    logic [BLK_W-1:0]  sc_blocks;
    logic              sc_ok;
    logic [ADDR_W-1:0] mk_base;
    logic [SIZE_W-1:0] mk_size;
    logic [3:0]        mk_page;
    logic [7:0]        mk_dec, mk_mctl, mk_pgctl, mk_xdec;
    logic [IRQN_W-1:0] iq_num;
    logic              iq_none;

    shmwin_scan #(.W(MCFG_W)) u_scan (
        .cfg    (st_q.c.mcfg),
        .idx    (sc_idx),
        .blocks (sc_blocks),
        .ok     (sc_ok)
    );

    shmwin_mask #(.ORIGIN(ORIGIN), .PG_SH(PG_SH), .CS16_EN(CS16_EN)) u_mask (
        .idx    (st_q.m.idx),
        .blocks (st_q.m.blocks),
        .base   (mk_base),
        .size   (mk_size),
        .page   (mk_page),
        .dec    (mk_dec),
        .mctl   (mk_mctl),
        .pgctl  (mk_pgctl),
        .xdec   (mk_xdec)
    );

    shmwin_irq u_irq (
        .code (st_q.m.irq),
        .num  (iq_num),
        .none (iq_none)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: capture on start
        st_d.c.vld = start;
        if (start) begin
            st_d.c.mcfg = mem_cfg;
            st_d.c.irq  = irq_code;
            st_d.c.wb_v = want_base_vld;
            st_d.c.wb   = want_base;
            st_d.c.ws_v = want_size_vld;
            st_d.c.ws   = want_size;
        end

        // stage 2: bit scan
        st_d.m.vld = st_q.c.vld;
        if (st_q.c.vld) begin
            st_d.m.ok     = sc_ok;
            st_d.m.idx    = sc_ok ? sc_idx : '0;
            st_d.m.blocks = sc_ok ? sc_blocks : '0;
            st_d.m.irq    = st_q.c.irq;
            st_d.m.wb_v   = st_q.c.wb_v;
            st_d.m.wb     = st_q.c.wb;
            st_d.m.ws_v   = st_q.c.ws_v;
            st_d.m.ws     = st_q.c.ws;
        end

        // stage 3: register values and result
        st_d.o.done = st_q.m.vld;
        if (st_q.m.vld) begin
            st_d.o.irq_num  = iq_num;
            st_d.o.irq_none = iq_none;
            st_d.o.bad      = ~st_q.m.ok;
            if (st_q.m.ok) begin
                st_d.o.base  = mk_base;
                st_d.o.size  = mk_size;
                st_d.o.page  = mk_page;
                st_d.o.dec   = mk_dec;
                st_d.o.mctl  = mk_mctl;
                st_d.o.pgctl = mk_pgctl;
                st_d.o.xdec  = mk_xdec;
                st_d.o.mism  = (st_q.m.wb_v && (st_q.m.wb != mk_base)) ||
                               (st_q.m.ws_v && (st_q.m.ws != mk_size));
            end else begin
                st_d.o.base  = '0;
                st_d.o.size  = '0;
                st_d.o.page  = '0;
                st_d.o.dec   = '0;
                st_d.o.mctl  = '0;
                st_d.o.pgctl = '0;
                st_d.o.xdec  = '0;
                st_d.o.mism  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.o.done;
    assign bad_cfg   = st_q.o.bad;
    assign mismatch  = st_q.o.mism;
    assign win_base  = st_q.o.base;
    assign win_size  = st_q.o.size;
    assign page      = st_q.o.page;
    assign dec_val   = st_q.o.dec;
    assign mctl_val  = st_q.o.mctl;
    assign pgctl_val = st_q.o.pgctl;
    assign xdec_val  = st_q.o.xdec;
    assign irq_num   = st_q.o.irq_num;
    assign irq_none  = st_q.o.irq_none;
endmodule

// File: rtl/shmwin_cfg_decoder_chk.sv
`timescale 1ns/1ps
module shmwin_cfg_decoder_chk
    import shmwin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              bad_cfg,
    input logic              mismatch,
    input logic [ADDR_W-1:0] win_base,
    input logic [SIZE_W-1:0] win_size,
    input logic [7:0]        dec_val,
    input logic [7:0]        pgctl_val,
    input logic [IRQN_W-1:0] irq_num,
    input logic              irq_none
);
    logic [2:0] start_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_sh_q <= '0;
        else        start_sh_q <= {start_sh_q[1:0], start};
    end

    assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done == start_sh_q[2]);

    assert_bad_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cfg |-> (win_base == '0 && win_size == '0 && dec_val == '0 && !mismatch));

    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bad_cfg) |-> (win_base[13:0] == '0 && win_base >= 20'hC0000));

    assert_mask_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bad_cfg) |-> ($countones(dec_val) == 32'(win_size >> 14)
                                && (pgctl_val ^ dec_val) == 8'hFF));

    assert_irq_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_none |-> (irq_num == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(win_base) && $stable(win_size) && $stable(dec_val)
                   && $stable(bad_cfg) && $stable(irq_num)));
endmodule

bind shmwin_cfg_decoder shmwin_cfg_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .bad_cfg   (bad_cfg),
    .mismatch  (mismatch),
    .win_base  (win_base),
    .win_size  (win_size),
    .dec_val   (dec_val),
    .pgctl_val (pgctl_val),
    .irq_num   (irq_num),
    .irq_none  (irq_none)
);

// File: tb/shmwin_cfg_decoder_bench.sv
`timescale 1ns/1ps
module shmwin_cfg_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mem_cfg = '0;
    logic [2:0]  irq_code = '0;
    logic        want_base_vld = 1'b0;
    logic [19:0] want_base = '0;
    logic        want_size_vld = 1'b0;
    logic [16:0] want_size = '0;
    logic        done, bad_cfg, mismatch, irq_none;
    logic [19:0] win_base;
    logic [16:0] win_size;
    logic [3:0]  page, irq_num;
    logic [7:0]  dec_val, mctl_val, pgctl_val, xdec_val;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    shmwin_cfg_decoder u_shmwin_cfg_decoder (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected values computed from the requirements
    typedef struct {
        logic        bad;
        logic [19:0] base;
        logic [16:0] size;
        logic [3:0]  pg;
        logic [7:0]  dec, mctl, pgctl, xdec;
        logic [3:0]  irq;
        logic        none;
    } exp_t;

    function automatic exp_t model(input logic [7:0] m, input logic [2:0] ic);
        exp_t e;
        int i, blk;
        logic [7:0] v;
        logic [15:0] mk;
        e = '{default: '0};
        i = 8;
        for (int b = 7; b >= 0; b--) if (m[b]) i = b;
        blk = 0;
        if (i < 8) begin
            v = m >> i;
            case (v)
                8'h01: blk = 1;
                8'h03: blk = 2;
                8'h07: blk = 3;
                8'h0F: blk = 4;
                default: blk = 0;
            endcase
        end
        e.bad = (blk == 0);
        if (!e.bad) begin
            e.base  = 20'(32'hC0000 + i * 32'h4000);
            e.size  = 17'(blk * 16384);
            e.pg    = 4'((e.base & 20'h3C000) >> 14);
            mk      = 16'(((1 << blk) - 1) << e.pg);
            e.dec   = mk[7:0];
            e.pgctl = ~mk[7:0];
            e.xdec  = 8'(((~mk >> 4) & 16'h00F0) | (mk >> 8));
            e.mctl  = 8'h10 | 8'({e.pg[1:0], 2'b00});
        end
        case (ic)
            3'd1: e.irq = 9;
            3'd2: e.irq = 3;
            3'd3: e.irq = 4;
            3'd4: e.irq = 5;
            3'd5: e.irq = 10;
            3'd6: e.irq = 11;
            default: e.irq = 0;
        endcase
        e.none = (ic == 3'd0 || ic == 3'd7);
        return e;
    endfunction

    task automatic check_out(input string req, input exp_t e);
        chk(req, "bad_cfg",   32'(bad_cfg),   32'(e.bad));
        chk("R2", "win_base", 32'(win_base),  32'(e.base));
        chk("R3", "win_size", 32'(win_size),  32'(e.size));
        chk("R5", "page",     32'(page),      32'(e.pg));
        chk("R5", "mctl_val", 32'(mctl_val),  32'(e.mctl));
        chk("R6", "dec_val",  32'(dec_val),   32'(e.dec));
        chk("R6", "pgctl_val",32'(pgctl_val), 32'(e.pgctl));
        chk("R7", "xdec_val", 32'(xdec_val),  32'(e.xdec));
        chk("R8", "irq_num",  32'(irq_num),   32'(e.irq));
        chk("R8", "irq_none", 32'(irq_none),  32'(e.none));
    endtask

    // one decode with full timing check (R1) and value checks
    task automatic run_one(input string req, input logic [7:0] m, input logic [2:0] ic,
                           input logic wbv, input logic [19:0] wb,
                           input logic wsv, input logic [16:0] ws,
                           input logic exp_mism);
        exp_t e;
        e = model(m, ic);
        @(negedge clk);
        mem_cfg = m; irq_code = ic;
        want_base_vld = wbv; want_base = wb; want_size_vld = wsv; want_size = ws;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1", "done early(1)", 32'(done), 0);
        @(negedge clk);
        chk("R1", "done early(2)", 32'(done), 0);
        @(negedge clk);
        chk("R1", "done on time", 32'(done), 1);
        check_out(req, e);
        chk("R9", "mismatch", 32'(mismatch), 32'(exp_mism));
        @(negedge clk);
        chk("R1", "done one cycle", 32'(done), 0);
        chk("R10", "base held", 32'(win_base), 32'(e.base));
    endtask

    task automatic t_reset();
        chk("R11", "done in reset", 32'(done), 0);
        chk("R11", "base in reset", 32'(win_base), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "done after reset", 32'(done), 0);
        chk("R11", "bad after reset", 32'(bad_cfg), 0);
        chk("R11", "dec after reset", 32'(dec_val), 0);
        chk("R11", "irq after reset", 32'(irq_num), 0);
    endtask

    task automatic t_windows();
        logic [7:0] cfgs [7] = '{8'h3C, 8'h70, 8'hC0, 8'h80, 8'h01, 8'h0F, 8'hE0};
        foreach (cfgs[k]) run_one("R3", cfgs[k], 3'd3, 0, '0, 0, '0, 0);
    endtask

    task automatic t_bad();
        logic [7:0] cfgs [6] = '{8'h00, 8'h05, 8'h1F, 8'hFF, 8'h90, 8'hA0};
        // a mismatching expected base must not raise mismatch on a bad byte (R4)
        foreach (cfgs[k]) run_one("R4", cfgs[k], 3'd2, 1, 20'hD0000, 0, '0, 0);
    endtask

    task automatic t_irq();
        for (int c = 0; c < 8; c++) run_one("R8", 8'h3C, 3'(c), 0, '0, 0, '0, 0);
    endtask

    task automatic t_mismatch();
        run_one("R9", 8'h70, 3'd1, 1, 20'hD0000, 1, 17'd49152, 0);
        run_one("R9", 8'h70, 3'd1, 1, 20'hC8000, 0, '0, 1);
        run_one("R9", 8'h70, 3'd1, 0, 20'hC8000, 1, 17'd65536, 1);
        run_one("R9", 8'h80, 3'd1, 0, 20'hC8000, 0, 17'd65536, 0);
    endtask

    task automatic t_hold();
        exp_t e;
        run_one("R10", 8'hC0, 3'd5, 0, '0, 0, '0, 0);
        e = model(8'hC0, 3'd5);
        @(negedge clk);
        mem_cfg = 8'h00; irq_code = 3'd0; want_base_vld = 1; want_base = '0;
        repeat (6) @(negedge clk);
        chk("R10", "no done without start", 32'(done), 0);
        check_out("R10", e);
        chk("R10", "mismatch held", 32'(mismatch), 0);
        want_base_vld = 0;
    endtask

    task automatic t_back_to_back();
        exp_t ea, eb;
        ea = model(8'h3C, 3'd4);
        eb = model(8'h05, 3'd6);
        @(negedge clk);
        mem_cfg = 8'h3C; irq_code = 3'd4; start = 1'b1;
        @(negedge clk);
        mem_cfg = 8'h05; irq_code = 3'd6;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R1", "b2b first done", 32'(done), 1);
        check_out("R1", ea);
        @(negedge clk);
        chk("R1", "b2b second done", 32'(done), 1);
        check_out("R4", eb);
        @(negedge clk);
        chk("R1", "b2b done drops", 32'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_windows();
        t_bad();
        t_irq();
        t_mismatch();
        t_hold();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule